// File: doc/BRIEF.md
# Bus Master Single-Beat Read Controller

This block sits between a local requester and a processor local bus. A command arrives on a local port with a target address, a priority and a lock flag. The block raises its bus request with that priority and lock and waits until the arbiter marks the bus as granted to it. It then presents the address with the read qualifier and holds the address tenure until the tenure ends. When the slave accepts the address, the block waits for the read-data acknowledge and reports completion.

An address tenure can end in four ways: slave accept, slave rearbitrate, arbiter timeout error, or local abort. A rearbitrate makes the block drop its request for one cycle and then ask again for the same address. An error or an abort ends the transfer with its own status pulse. The abort request goes straight through to the bus combinationally and does not wait for a clock edge. The transfer then closes at the next edge.

Top module: `rd_master`

## Requirements
- R1: After reset, `cmdReady` is 1, and `busReq`, `busAddrValid`, `busRead`, `busAbort` and the three status pulses are 0.
- R2: A command is accepted only when `cmdValid` is high while `cmdReady` is high. In the next cycle `busReq` is 1 and `busPrio` and `busLock` show the captured values. `cmdValid` while busy changes nothing. `busPrio` and `busLock` read 0 whenever `busReq` is 0.
- R3: `busGrant` seen while requesting starts the address phase in the next cycle: `busAddrValid`=1, `busRead`=1 and `busAddr` equal to the captured address. `busReq` stays 1 during this phase. `busAddr` reads 0 outside the address phase.
- R4: `slvAddrAck` during the address phase makes `busReq`, `busPrio`, `busLock` and `busAddrValid` 0 in the next cycle. The block then waits for read data.
- R5: `rdDAck` while waiting for data gives a one-cycle `donePulse` in the next cycle, and `cmdReady` returns to 1 in that cycle.
- R6: `arbErr` during the address phase gives a one-cycle `errPulse` in the next cycle, with the request dropped and `cmdReady` at 1. Error wins over rearbitrate and acknowledge in the same cycle.
- R7: `slvRearb` during the address phase (with no error) drops `busReq` and `busAddrValid` for exactly one cycle. After that `busReq` is 1 again with the same address, and a new grant is needed. Rearbitrate wins over acknowledge in the same cycle.
- R8: `busAbort` equals `abortReq` in the same cycle while requesting, in the address phase or in the one-cycle back-off. It is 0 when idle and while waiting for data.
- R9: An abort that reaches `busAbort` gives a one-cycle `abortPulse` in the next cycle, with the request dropped and `cmdReady` at 1. Abort wins over every other termination.
- R10: At most one of `donePulse`, `errPulse` and `abortPulse` is high in any cycle, and none is high for two cycles in a row.
- R11: Inputs that arrive in the wrong state have no effect. These are `busGrant`, `slvAddrAck`, `slvRearb` and `arbErr` when idle or waiting for data, `rdDAck` outside the data wait, and `abortReq` while waiting for data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Local read command strobe |
| cmdAddr | input | AW | Target address of the command |
| cmdPrio | input | PW | Request priority for the command |
| cmdLock | input | 1 | Bus-lock flag for the command |
| abortReq | input | 1 | Local abort, passed through combinationally |
| cmdReady | output | 1 | Idle, a command is accepted |
| donePulse | output | 1 | Read completed (one cycle) |
| errPulse | output | 1 | Timeout error reported (one cycle) |
| abortPulse | output | 1 | Transfer aborted (one cycle) |
| busReq | output | 1 | Bus request |
| busPrio | output | PW | Request priority |
| busLock | output | 1 | Bus-lock flag |
| busAddrValid | output | 1 | Address phase active |
| busAddr | output | AW | Presented address |
| busRead | output | 1 | Read transfer qualifier |
| busAbort | output | 1 | Abort to the bus |
| busGrant | input | 1 | Arbiter address-valid for this master |
| slvAddrAck | input | 1 | Slave address acknowledge |
| slvRearb | input | 1 | Slave rearbitrate |
| arbErr | input | 1 | Arbiter address timeout error |
| rdDAck | input | 1 | Read-data acknowledge for this master |

## Verification
The hardest case to reach is a tenure where several terminations arrive in the same cycle, or where an abort lands in the one-cycle back-off after a rearbitrate. The stimulus reaches these by driving the terminating inputs together on chosen cycles after a grant. It also times an abort to the exact cycle after a rearbitrate. A behavioural model in the bench tracks the expected phase and compares every output on every clock. This includes the combinational abort path, checked against the abort level in the same cycle.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_XFER,
    ST_DATA,
    ST_BACK
  } rdState_t;

  typedef struct packed {
    logic load;     // capture command fields
    logic reqOn;    // request, priority and lock active
    logic present;  // address phase: address and qualifier shown
  } rdStrobe_t;
endpackage

// File: rtl/rdm_ctrl.sv
module rdm_ctrl
  import rdm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      abortReq,
  input  logic      busGrant,
  input  logic      slvAddrAck,
  input  logic      slvRearb,
  input  logic      arbErr,
  input  logic      rdDAck,
  output rdStrobe_t strobe,
  output logic      cmdReady,
  output logic      busReq,
  output logic      busAbort,
  output logic      donePulse,
  output logic      errPulse,
  output logic      abortPulse
);
  rdState_t state, nextState;
  logic abortLive;
  logic doneNext, errNext, abortNext;

  // Abort is meaningful only while the tenure is open.
  assign abortLive = (state == ST_REQ) || (state == ST_XFER) || (state == ST_BACK);
  assign busAbort  = abortReq && abortLive;

  always_comb begin
    nextState = state;
    doneNext  = 1'b0;
    errNext   = 1'b0;
    abortNext = 1'b0;
    unique case (state)
      ST_IDLE: if (cmdValid) nextState = ST_REQ;
      ST_REQ: begin
        if (abortReq) begin nextState = ST_IDLE; abortNext = 1'b1; end
        else if (busGrant) nextState = ST_XFER;
      end
      ST_XFER: begin
        if (abortReq)        begin nextState = ST_IDLE; abortNext = 1'b1; end
        else if (arbErr)     begin nextState = ST_IDLE; errNext   = 1'b1; end
        else if (slvRearb)   nextState = ST_BACK;
        else if (slvAddrAck) nextState = ST_DATA;
      end
      ST_DATA: if (rdDAck) begin nextState = ST_IDLE; doneNext = 1'b1; end
      ST_BACK: begin
        if (abortReq) begin nextState = ST_IDLE; abortNext = 1'b1; end
        else nextState = ST_REQ;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      donePulse  <= 1'b0;
      errPulse   <= 1'b0;
      abortPulse <= 1'b0;
    end else begin
      state      <= nextState;
      donePulse  <= doneNext;
      errPulse   <= errNext;
      abortPulse <= abortNext;
    end
  end

  assign cmdReady       = (state == ST_IDLE);
  assign busReq         = (state == ST_REQ) || (state == ST_XFER);
  assign strobe.load    = cmdReady && cmdValid;
  assign strobe.reqOn   = busReq;
  assign strobe.present = (state == ST_XFER);

  a_r10_one_status: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({donePulse, errPulse, abortPulse}));
  a_r10_pulse_short: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse || errPulse || abortPulse) |=> !(donePulse || errPulse || abortPulse));
  a_r9_abort_report: assert property (@(posedge clk) disable iff (!rstN)
    busAbort |=> (abortPulse && cmdReady && !busReq));
  a_r4_req_drop: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.present && slvAddrAck) |=> !busReq);
  a_r7_backoff: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.present && slvRearb && !arbErr && !abortReq) |=> (!busReq && !cmdReady));
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (!busReq && !busAbort));
endmodule

// File: rtl/rdm_dpath.sv
module rdm_dpath
  import rdm_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  rdStrobe_t     strobe,
  input  logic [AW-1:0] cmdAddr,
  input  logic [PW-1:0] cmdPrio,
  input  logic          cmdLock,
  output logic [AW-1:0] busAddr,
  output logic [PW-1:0] busPrio,
  output logic          busLock,
  output logic          busAddrValid,
  output logic          busRead
);
  logic [AW-1:0] addrReg;
  logic [PW-1:0] prioReg;
  logic          lockReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      prioReg <= '0;
      lockReg <= 1'b0;
    end else if (strobe.load) begin
      addrReg <= cmdAddr;
      prioReg <= cmdPrio;
      lockReg <= cmdLock;
    end
  end

  assign busAddr      = strobe.present ? addrReg : '0;
  assign busAddrValid = strobe.present;
  assign busRead      = strobe.present;
  assign busPrio      = strobe.reqOn ? prioReg : '0;
  assign busLock      = strobe.reqOn && lockReg;

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.present && $past(strobe.present)) |-> $stable(busAddr));
  a_r2_no_load_busy: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reqOn |-> !strobe.load);
endmodule

// File: rtl/rd_master.sv
module rd_master
  import rdm_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [AW-1:0] cmdAddr,
  input  logic [PW-1:0] cmdPrio,
  input  logic          cmdLock,
  input  logic          abortReq,
  output logic          cmdReady,
  output logic          donePulse,
  output logic          errPulse,
  output logic          abortPulse,
  output logic          busReq,
  output logic [PW-1:0] busPrio,
  output logic          busLock,
  output logic          busAddrValid,
  output logic [AW-1:0] busAddr,
  output logic          busRead,
  output logic          busAbort,
  input  logic          busGrant,
  input  logic          slvAddrAck,
  input  logic          slvRearb,
  input  logic          arbErr,
  input  logic          rdDAck
);
  rdStrobe_t strobe;

  rdm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .abortReq(abortReq),
    .busGrant(busGrant), .slvAddrAck(slvAddrAck), .slvRearb(slvRearb),
    .arbErr(arbErr), .rdDAck(rdDAck), .strobe(strobe), .cmdReady(cmdReady),
    .busReq(busReq), .busAbort(busAbort), .donePulse(donePulse),
    .errPulse(errPulse), .abortPulse(abortPulse)
  );

  rdm_dpath #(.AW(AW), .PW(PW)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdAddr(cmdAddr),
    .cmdPrio(cmdPrio), .cmdLock(cmdLock), .busAddr(busAddr),
    .busPrio(busPrio), .busLock(busLock), .busAddrValid(busAddrValid),
    .busRead(busRead)
  );
endmodule

// File: tb/sim_rd_master.sv
module sim_rd_master;
  localparam int AW = 32;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 0, cmdLock = 0, abortReq = 0;
  logic [AW-1:0] cmdAddr = '0;
  logic [PW-1:0] cmdPrio = '0;
  logic busGrant = 0, slvAddrAck = 0, slvRearb = 0, arbErr = 0, rdDAck = 0;
  logic cmdReady, donePulse, errPulse, abortPulse, busReq, busLock;
  logic busAddrValid, busRead, busAbort;
  logic [PW-1:0] busPrio;
  logic [AW-1:0] busAddr;

  int checks = 0;
  int errors = 0;
  bit modelOn = 0;

  always #2 clk = ~clk;

  rd_master #(.AW(AW), .PW(PW)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .cmdPrio(cmdPrio), .cmdLock(cmdLock), .abortReq(abortReq),
    .cmdReady(cmdReady), .donePulse(donePulse), .errPulse(errPulse),
    .abortPulse(abortPulse), .busReq(busReq), .busPrio(busPrio),
    .busLock(busLock), .busAddrValid(busAddrValid), .busAddr(busAddr),
    .busRead(busRead), .busAbort(busAbort), .busGrant(busGrant),
    .slvAddrAck(slvAddrAck), .slvRearb(slvRearb), .arbErr(arbErr),
    .rdDAck(rdDAck)
  );

  // Reference model: 0 idle, 1 request, 2 address phase, 3 data wait, 4 back-off
  int mSt = 0;
  logic [AW-1:0] mAddr = '0;
  logic [PW-1:0] mPrio = '0;
  logic mLock = 0, mDone = 0, mErr = 0, mAbt = 0;

  always @(posedge clk) begin
    mDone <= 0; mErr <= 0; mAbt <= 0;
    if (!rstN) mSt <= 0;
    else case (mSt)
      0: if (cmdValid) begin mSt <= 1; mAddr <= cmdAddr; mPrio <= cmdPrio; mLock <= cmdLock; end
      1: if (abortReq) begin mSt <= 0; mAbt <= 1; end else if (busGrant) mSt <= 2;
      2: if (abortReq) begin mSt <= 0; mAbt <= 1; end
         else if (arbErr) begin mSt <= 0; mErr <= 1; end
         else if (slvRearb) mSt <= 4;
         else if (slvAddrAck) mSt <= 3;
      3: if (rdDAck) begin mSt <= 0; mDone <= 1; end
      4: if (abortReq) begin mSt <= 0; mAbt <= 1; end else mSt <= 1;
      default: mSt <= 0;
    endcase
  end

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (modelOn) begin
    logic eReq, ePres;
    eReq  = (mSt == 1) || (mSt == 2);
    ePres = (mSt == 2);
    chk("R2 cmdReady", AW'(cmdReady), AW'(mSt == 0));
    chk("R3 busReq", AW'(busReq), AW'(eReq));
    chk("R2 busPrio", AW'(busPrio), eReq ? AW'(mPrio) : '0);
    chk("R2 busLock", AW'(busLock), AW'(eReq && mLock));
    chk("R3 busAddrValid", AW'(busAddrValid), AW'(ePres));
    chk("R3 busRead", AW'(busRead), AW'(ePres));
    chk("R3 busAddr", busAddr, ePres ? mAddr : '0);
    chk("R8 busAbort", AW'(busAbort), AW'(abortReq && (mSt == 1 || mSt == 2 || mSt == 4)));
    chk("R5 donePulse", AW'(donePulse), AW'(mDone));
    chk("R6 errPulse", AW'(errPulse), AW'(mErr));
    chk("R9 abortPulse", AW'(abortPulse), AW'(mAbt));
    chk("R10 exclusive", AW'($countones({donePulse, errPulse, abortPulse}) <= 1), AW'(1));
  end

  // One cycle of stimulus: bits {cmd, grant, ack, rearb, err, dack, abort}
  task automatic step(logic [6:0] v, logic [AW-1:0] a = '0, logic [PW-1:0] p = '0, logic l = 0);
    {cmdValid, busGrant, slvAddrAck, slvRearb, arbErr, rdDAck, abortReq} = v;
    cmdAddr = a; cmdPrio = p; cmdLock = l;
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(7'b0);
  endtask

  localparam logic [6:0] CMD = 7'b1000000, GNT = 7'b0100000, ACK = 7'b0010000,
                         RB = 7'b0001000, ERR = 7'b0000100, DAK = 7'b0000010,
                         ABT = 7'b0000001;

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 cmdReady", AW'(cmdReady), AW'(1));
    chk("R1 busReq", AW'(busReq), AW'(0));
    chk("R1 pulses", AW'({donePulse, errPulse, abortPulse, busAbort}), AW'(0));
    rstN = 1;
    modelOn = 1;
    // R11: stray bus inputs in idle do nothing
    step(GNT | ACK | RB | ERR | DAK | ABT);
    idle(1);
    chk("R11 idle stray", AW'(cmdReady), AW'(1));
    // Normal read with waiting and stray inputs
    step(CMD, 32'hA5A0_1230, 2'd2, 1'b1);
    step(DAK | ACK);                            // R11: ignored while requesting
    step(CMD, 32'h0BAD_0BAD, 2'd1, 1'b0);       // R2: ignored command
    step(GNT);
    step(DAK); idle(2);                         // slave holds off
    step(ACK);
    step(GNT | ERR | ABT);                      // R11: ignored in data wait
    chk("R11 data wait", AW'(busAbort), AW'(0));
    idle(1);
    step(DAK);
    idle(2);
    // Rearbitrate then complete
    step(CMD, 32'h0000_0040, 2'd3, 1'b0);
    step(GNT);
    step(RB | ACK);                             // R7: rearbitrate wins over ack
    step(GNT);                                  // back-off cycle: grant ignored
    step(7'b0);
    step(GNT);
    step(ACK);
    step(DAK);
    idle(1);
    // R6: error wins over rearb and ack
    step(CMD, 32'hFFFF_FFFC, 2'd0, 1'b1);
    step(GNT);
    step(ERR | RB | ACK);
    idle(2);
    // R9: abort while requesting, in address phase, in back-off
    step(CMD, 32'h1111_0000, 2'd1, 1'b1);
    step(ABT | GNT);
    idle(1);
    step(CMD, 32'h2222_0000, 2'd2, 1'b0);
    step(GNT);
    step(ABT | ERR | ACK | RB);
    idle(1);
    step(CMD, 32'h3333_0000, 2'd3, 1'b1);
    step(GNT);
    step(RB);
    step(ABT);
    idle(2);
    // Back-to-back commands
    for (int k = 0; k < 4; k++) begin
      step(CMD, AW'(32'h100 * (k + 1)), PW'(k), k[0]);
      step(GNT);
      if (k == 2) step(ERR); else begin step(ACK); step(DAK); end
    end
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule